// File: doc/BRIEF.md
# Flash Block-Protection Range Checker

This block keeps a copy of an 8-bit flash status register. It turns the block-protect field and the top/bottom anchor bit into one protected address window. Each request gives a start address and a byte length. For every request the block answers two questions. The first is whether the whole range lies inside the window. The second is whether no byte of the range touches the window. The block also returns a write-allowed flag that gates program and erase operations on that range.

The window length is a power of two. Its smallest step comes from the device size, the sector count and the number of protect bits in use. Each higher code doubles the length, up to the whole array. The window sits at the top of the array unless bottom anchoring is enabled and selected. Four configuration straps choose the register layout: a fourth protect bit (at bit 5 or at bit 6), top/bottom support, and the position of the anchor bit (bit 5 or bit 6). Device size and sector count are parameters. Results are registered and appear one clock after the request strobe.

Top module: `bpp_range_checker`

## Requirements
- R1: While reset is asserted and after its release, until the first request, `lock_o`, `unlock_o` and `write_ok_o` are 0 and the stored status register is 0x00.
- R2: A pulse on `sr_load` stores `sr_wdata` at the clock edge. A request strobed in the same cycle as a load is judged against the value held before that load.
- R3: The protect code is built as {B3,sr[4],sr[3],sr[2]}. B3 is 0 when `cfg_bp4_en`=0. Otherwise B3 is sr[6] when `cfg_bp4_hi`=1, and sr[5] when `cfg_bp4_hi`=0. Bits 0, 1 and 7 have no effect on any result.
- R4: Code 0 protects nothing. Any request of non-zero length then gives locked=0 and unlocked=1.
- R5: Each layout has a minimum window length. Let usable = 2^bits − 2 and needed = log2(sector count). The minimum is one sector, shifted left by (needed − usable) when needed exceeds usable. The window length is this minimum shifted left by (code − 1), capped at the device size. With the defaults (8 MiB, 128 sectors) three bits give 128 KiB for code 1, 4 MiB for code 6 and the whole array for code 7. Four bits give 64 KiB for code 1 and the whole array for codes 8 to 15.
- R6: The anchor bit is sr[6] when `cfg_tb_hi`=1, and sr[5] otherwise. It is ignored when `cfg_tb_en`=0. When it is honoured and set, the window is [0, len). Otherwise the window is [size − len, size).
- R7: locked=1 when the request start is at or above the window start and the request end (start + length) is at or below the window end.
- R8: unlocked=1 when the request start is at or above the window end, or the request end is at or below the window start.
- R9: A request of length 0 gives locked=1 and unlocked=1.
- R10: `write_ok_o` equals the unlocked result of the same request.
- R11: Results update on the clock edge at which `req_valid` is high. Between requests they hold their value, even across status-register loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_load | input | 1 | Load strobe for the status register copy |
| sr_wdata | input | 8 | Status register value to load |
| cfg_bp4_en | input | 1 | Enables the fourth protect bit |
| cfg_bp4_hi | input | 1 | Fourth protect bit at sr[6] (1) or sr[5] (0) |
| cfg_tb_en | input | 1 | Enables bottom anchoring |
| cfg_tb_hi | input | 1 | Anchor bit at sr[6] (1) or sr[5] (0) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | DEV_BYTES_LOG2+1 | Request start byte address |
| req_len | input | DEV_BYTES_LOG2+1 | Request length in bytes |
| lock_o | output | 1 | Range fully inside the window |
| unlock_o | output | 1 | Range fully outside the window |
| write_ok_o | output | 1 | Program/erase allowed on the range |

## Verification
A wrong internal state shows up on the result flags one clock after the next request. A bad decoded code or a wrong minimum length moves a window edge. Requests placed exactly on each edge and one byte across it make such a shift flip `lock_o` or `unlock_o` at once. A wrong anchor choice swaps which end of the array reports protected. A stale or early status-register value shows up in the request strobed in the same cycle as a load. Result registers that leak between requests show up as a change while `req_valid` is low.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  typedef struct packed {
    logic bp4_en;
    logic bp4_hi;
    logic tb_en;
    logic tb_hi;
  } bpp_cfg_t;
endpackage

// File: rtl/bpp_status_reg.sv
module bpp_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] wdata,
  output logic [7:0] sr_q
);
  logic [7:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load) sr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 8'h00;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/bpp_window_calc.sv
module bpp_window_calc
  import bpp_pkg::*;
#(
  parameter int DEV_BYTES_LOG2    = 23,
  parameter int SECTOR_COUNT_LOG2 = 7,
  localparam int ADDR_W = DEV_BYTES_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:2]        sr_bits,
  input  bpp_cfg_t          cfg,
  output logic [ADDR_W-1:0] win_start,
  output logic [ADDR_W-1:0] win_end
);
  localparam int SECTOR_LOG2 = DEV_BYTES_LOG2 - SECTOR_COUNT_LOG2;
  localparam int NCODES      = 16;
  localparam logic [ADDR_W-1:0] DEV_SIZE = ADDR_W'(1) << DEV_BYTES_LOG2;

  function automatic int min_log2(input int nbits);
    int usable;
    usable = (1 << nbits) - 2;
    if (SECTOR_COUNT_LOG2 > usable) return SECTOR_LOG2 + SECTOR_COUNT_LOG2 - usable;
    return SECTOR_LOG2;
  endfunction

  function automatic logic [ADDR_W-1:0] sat_len(input int lg);
    if (lg >= DEV_BYTES_LOG2) return DEV_SIZE;
    return ADDR_W'(1) << lg;
  endfunction

  localparam int MIN3 = min_log2(3);
  localparam int MIN4 = min_log2(4);

  logic [ADDR_W-1:0] len3 [NCODES];
  logic [ADDR_W-1:0] len4 [NCODES];

  genvar k;
  generate
    for (k = 0; k < NCODES; k++) begin : g_len
      if (k == 0) begin : g_zero
        assign len3[k] = '0;
        assign len4[k] = '0;
      end else begin : g_pow
        assign len3[k] = sat_len(MIN3 + k - 1);
        assign len4[k] = sat_len(MIN4 + k - 1);
      end
    end
  endgenerate

  logic       bp_hi;
  logic [3:0] code;
  logic       bottom;
  logic [ADDR_W-1:0] win_len;

  always_comb begin
    bp_hi   = cfg.bp4_en & (cfg.bp4_hi ? sr_bits[6] : sr_bits[5]);
    code    = {bp_hi, sr_bits[4:2]};
    bottom  = cfg.tb_en & (cfg.tb_hi ? sr_bits[6] : sr_bits[5]);
    win_len = cfg.bp4_en ? len4[code] : len3[code];
    if (code == 4'd0) begin
      win_start = '0;
      win_end   = '0;
    end else if (bottom) begin
      win_start = '0;
      win_end   = win_len;
    end else begin
      win_start = DEV_SIZE - win_len;
      win_end   = DEV_SIZE;
    end
  end

  // R5, R6: the window never leaves the array and never inverts
  a_r5_window_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end <= DEV_SIZE) && (win_start <= win_end));
endmodule

// File: rtl/bpp_range_cmp.sv
module bpp_range_cmp #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] win_start,
  input  logic [ADDR_W-1:0] win_end,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  output logic              locked,
  output logic              unlocked
);
  logic [ADDR_W:0] req_end;
  logic            empty;

  always_comb begin
    req_end  = {1'b0, req_addr} + {1'b0, req_len};
    empty    = (req_len == '0);
    locked   = empty ||
               ((req_addr >= win_start) && (req_end <= {1'b0, win_end}));
    unlocked = empty ||
               (req_addr >= win_end) || (req_end <= {1'b0, win_start});
  end
endmodule

// File: rtl/bpp_range_checker.sv
module bpp_range_checker
  import bpp_pkg::*;
#(
  parameter int DEV_BYTES_LOG2    = 23,
  parameter int SECTOR_COUNT_LOG2 = 7,
  localparam int ADDR_W = DEV_BYTES_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_load,
  input  logic [7:0]        sr_wdata,
  input  logic              cfg_bp4_en,
  input  logic              cfg_bp4_hi,
  input  logic              cfg_tb_en,
  input  logic              cfg_tb_hi,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  output logic              lock_o,
  output logic              unlock_o,
  output logic              write_ok_o
);
  bpp_cfg_t          cfg;
  logic [7:0]        sr_q;
  logic [ADDR_W-1:0] win_start, win_end;
  logic              locked_c, unlocked_c;
  logic              lock_d, unlock_d, write_ok_d;
  logic              unused_sr_bits;

  assign cfg = '{bp4_en: cfg_bp4_en, bp4_hi: cfg_bp4_hi,
                 tb_en: cfg_tb_en, tb_hi: cfg_tb_hi};
  assign unused_sr_bits = ^{sr_q[7], sr_q[1:0]};

  bpp_status_reg i_sr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sr_load),
    .wdata (sr_wdata),
    .sr_q  (sr_q)
  );

  bpp_window_calc #(
    .DEV_BYTES_LOG2    (DEV_BYTES_LOG2),
    .SECTOR_COUNT_LOG2 (SECTOR_COUNT_LOG2)
  ) i_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .sr_bits   (sr_q[6:2]),
    .cfg       (cfg),
    .win_start (win_start),
    .win_end   (win_end)
  );

  bpp_range_cmp #(.ADDR_W(ADDR_W)) i_cmp (
    .win_start (win_start),
    .win_end   (win_end),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .locked    (locked_c),
    .unlocked  (unlocked_c)
  );

  always_comb begin
    lock_d     = lock_o;
    unlock_d   = unlock_o;
    write_ok_d = write_ok_o;
    if (req_valid) begin
      lock_d     = locked_c;
      unlock_d   = unlocked_c;
      write_ok_d = unlocked_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_o     <= 1'b0;
      unlock_o   <= 1'b0;
      write_ok_o <= 1'b0;
    end else begin
      lock_o     <= lock_d;
      unlock_o   <= unlock_d;
      write_ok_o <= write_ok_d;
    end
  end

  // R9: an empty request reports both states
  a_r9_zero_len_both: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len == '0) |=> (lock_o && unlock_o));

  // R7, R8: a non-empty range cannot be fully inside and fully outside
  a_r8_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len != '0) |=> !(lock_o && unlock_o));

  // R10: write permission follows the unlocked answer
  a_r10_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (write_ok_o == unlock_o));

  // R11: results hold between requests
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(lock_o) && $stable(unlock_o) && $stable(write_ok_o)));
endmodule

// File: tb/test_bpp_range_checker.sv
module test_bpp_range_checker;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sr_load;
  logic [7:0]    sr_wdata;
  logic          cfg_bp4_en, cfg_bp4_hi, cfg_tb_en, cfg_tb_hi;
  logic          req_valid;
  logic [AW-1:0] req_addr, req_len;
  logic          lock_o, unlock_o, write_ok_o;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bpp_range_checker i_bpp_range_checker (
    .clk(clk), .rst_n(rst_n), .sr_load(sr_load), .sr_wdata(sr_wdata),
    .cfg_bp4_en(cfg_bp4_en), .cfg_bp4_hi(cfg_bp4_hi),
    .cfg_tb_en(cfg_tb_en), .cfg_tb_hi(cfg_tb_hi),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .lock_o(lock_o), .unlock_o(unlock_o), .write_ok_o(write_ok_o)
  );

  task automatic compare(input string tag, input bit el, input bit eu);
    n_vec++;
    if (lock_o !== el || unlock_o !== eu || write_ok_o !== eu) begin
      n_miss++;
      $display("FAIL %s: lock/unlock/wr = %b%b%b expected %b%b%b",
               tag, lock_o, unlock_o, write_ok_o, el, eu, eu);
    end
  endtask

  task automatic load_sr(input logic [7:0] v);
    @(negedge clk);
    sr_load = 1'b1; sr_wdata = v;
    @(negedge clk);
    sr_load = 1'b0;
  endtask

  task automatic set_cfg(input bit b4, input bit b4hi, input bit tb, input bit tbhi);
    @(negedge clk);
    cfg_bp4_en = b4; cfg_bp4_hi = b4hi; cfg_tb_en = tb; cfg_tb_hi = tbhi;
  endtask

  task automatic check_req(input string tag, input int addr, input int len,
                           input bit el, input bit eu);
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(addr); req_len = AW'(len);
    @(negedge clk);
    req_valid = 1'b0;
    compare(tag, el, eu);
  endtask

  task automatic t_reset;
    compare("R1 reset outputs", 1'b0, 1'b0);
    check_req("R1 status zero after reset", 0, 'h1000, 1'b0, 1'b1);
  endtask

  task automatic t_empty_code;
    set_cfg(0, 0, 0, 0);
    load_sr(8'h83); // R3: bits 0,1,7 set, code 0
    check_req("R3 low/high bits ignored", 0, 'h800000, 1'b0, 1'b1);
    check_req("R4 code0 top range", 'h7FF000, 'h1000, 1'b0, 1'b1);
  endtask

  task automatic t_three_bit;
    set_cfg(0, 0, 0, 0);
    load_sr(8'h04); // code 1: [0x7E0000,0x800000)
    check_req("R5 code1 window exact", 'h7E0000, 'h20000, 1'b1, 1'b0);
    check_req("R7 code1 straddles start", 'h7DFFFF, 2, 1'b0, 1'b0);
    check_req("R8 ends at window start", 0, 'h7E0000, 1'b0, 1'b1);
    check_req("R7 one byte too low", 'h7DFFFF, 'h20001, 1'b0, 1'b0);
    load_sr(8'h18); // code 6: [0x400000,0x800000)
    check_req("R5 code6 window exact", 'h400000, 'h400000, 1'b1, 1'b0);
    check_req("R8 code6 byte below", 'h3FFFFF, 1, 1'b0, 1'b1);
    load_sr(8'h1C); // code 7: whole array
    check_req("R5 code7 whole array", 0, 'h800000, 1'b1, 1'b0);
    check_req("R9 zero length", 'h123, 0, 1'b1, 1'b1);
  endtask

  task automatic t_anchor;
    set_cfg(0, 0, 1, 0);
    load_sr(8'h24); // code 1, anchor bit5 -> [0,0x20000)
    check_req("R6 bottom window", 0, 'h20000, 1'b1, 1'b0);
    check_req("R6 above bottom window", 'h20000, 'h100, 1'b0, 1'b1);
    set_cfg(0, 0, 0, 0);
    check_req("R6 anchor ignored when disabled", 0, 'h20000, 1'b0, 1'b1);
    set_cfg(0, 0, 1, 1);
    check_req("R6 bit5 ignored when anchor at 6", 'h7E0000, 'h20000, 1'b1, 1'b0);
    load_sr(8'h44); // code 1, anchor bit6
    check_req("R6 bottom via bit6", 0, 'h20000, 1'b1, 1'b0);
  endtask

  task automatic t_four_bit;
    set_cfg(1, 0, 0, 0);
    load_sr(8'h04); // code 1: 64 KiB at top
    check_req("R5 four-bit code1 64KiB", 'h7F0000, 'h10000, 1'b1, 1'b0);
    check_req("R5 four-bit below window", 'h7E0000, 'h10000, 1'b0, 1'b1);
    load_sr(8'h20); // R3: bit5 is the fourth bit -> code 8 full
    check_req("R3 fourth bit at 5 code8", 0, 'h800000, 1'b1, 1'b0);
    set_cfg(1, 1, 0, 0);
    check_req("R3 bit5 ignored when fourth at 6", 0, 'h1000, 1'b0, 1'b1);
    load_sr(8'h44); // code 9 saturates
    check_req("R5 code9 saturates", 0, 'h800000, 1'b1, 1'b0);
    load_sr(8'h0C); // code 3: 256 KiB
    check_req("R5 four-bit code3", 'h7C0000, 'h40000, 1'b1, 1'b0);
    check_req("R7 code3 one byte low", 'h7BFFFF, 'h40000, 1'b0, 1'b0);
  endtask

  task automatic t_ordering;
    set_cfg(0, 0, 0, 0);
    load_sr(8'h1C);
    @(negedge clk);
    sr_load = 1'b1; sr_wdata = 8'h00;
    req_valid = 1'b1; req_addr = '0; req_len = AW'('h1000);
    @(negedge clk);
    sr_load = 1'b0; req_valid = 1'b0;
    compare("R2 same-cycle load uses old value", 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    compare("R11 hold across load", 1'b1, 1'b0);
    check_req("R2 new value after load", 0, 'h1000, 1'b0, 1'b1);
    req_addr = '0; req_len = '0;
    repeat (2) @(negedge clk);
    compare("R11 hold with input change", 1'b0, 1'b1);
    check_req("R10 write follows unlock", 'h400000, 'h10, 1'b0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; sr_load = 1'b0; sr_wdata = '0; req_valid = 1'b0;
    req_addr = '0; req_len = '0;
    cfg_bp4_en = 0; cfg_bp4_hi = 0; cfg_tb_en = 0; cfg_tb_hi = 0;
    repeat (3) @(negedge clk);
    compare("R1 outputs in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_empty_code;
    t_three_bit;
    t_anchor;
    t_four_bit;
    t_ordering;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_vec++;
      n_miss++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end
endmodule